// File: doc/BRIEF.md
# Output Compare Timer Channel

This block is a timer with one output compare channel. A counter advances by one on every clock cycle in which the tick enable input is high. After the cycle in which it holds the modulo value, it returns to zero. That return to zero is the overflow event, and the time between two overflows is one period.

A compare register is checked against the count. On a match, the block can toggle, clear or set the output pin, and it raises a compare flag. Both flags stay set until software clears them by writing ones through the register port.

The compare register is unbuffered, so a write takes effect on the next clock. Suppose the count has already passed the new value but has not yet reached the old one. Then no compare happens in that period.

In PWM mode, the pin is driven to its active level on each overflow and returns to its inactive level on the compare match. The modulo register sets the period and the compare register sets the pulse width. A polarity bit selects active-high or active-low pulses.

Top module: `oc_timer_chan`

## Requirements
- R1: While reset is asserted and after it is released, the count, the pin, the compare flag and the overflow flag are all 0. The modulo register resets to all ones, the compare register to 0 and the control register to 0.
- R2: On a tick cycle where the count is below the modulo value, the count increments by one. On a tick cycle where the count is at or above the modulo value, it returns to 0 and the overflow flag is set at the same clock edge. Writes use `wr_addr` 0 for the modulo register.
- R3: While `tick_en` is low, the count, the pin and both flags keep their values.
- R4: In normal mode, the control register is written at `wr_addr` 2. Its field `wr_data[1:0]` selects the compare action: 0 none, 1 toggle, 2 clear, 3 set. The action is applied at the edge of a tick cycle in which the count equals the compare register (`wr_addr` 1).
- R5: The compare flag is set at the edge of every tick cycle in which the count equals the compare value and the compare value is not above the modulo value.
- R6: A write to `wr_addr` 3 clears the compare flag if `wr_data[0]` is 1 and the overflow flag if `wr_data[1]` is 1. A zero bit leaves its flag unchanged, and a new event in the same cycle takes priority over the clear.
- R7: A compare write takes effect on the next clock. If the count is already past the new value, no compare occurs before the next overflow.
- R8: With `wr_data[2]` (PWM enable) set in the control register and `wr_data[3]` (polarity) at 0, the pin goes to 1 on overflow and to 0 on compare. Over each full period after the first overflow, the pin is 1 exactly while count ≤ compare.
- R9: With PWM enabled and polarity 1, the pin levels are inverted: after the first overflow, the pin is 0 exactly while count ≤ compare.
- R10: When overflow and compare occur in the same tick cycle in PWM mode, the overflow level wins. A compare value above the modulo value never matches, so the pin stays at its overflow level (100% duty cycle).
- R11: Every modulo value from 0 to 255 is accepted, giving periods of 1 to 256 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Prescaler enable: the counter advances only when this is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 modulo, 1 compare, 2 control, 3 flag clear |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current count |
| pin_o | output | 1 | Channel output pin |
| cmp_flag_o | output | 1 | Compare interrupt flag |
| ovf_flag_o | output | 1 | Overflow interrupt flag |

## Verification
The bench builds the block with the default 8-bit counter. It uses small modulo values of 5 and 9, so the bench can check every wrap, every compare position and every pin edge cycle by cycle. A modulo of 255 covers the full 256-tick period. Compare values are placed below the modulo, equal to it and above it, which reaches the overflow-wins tie and the 100% duty case. A compare write made after the count has passed the new value shows the missed compare.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } cmp_act_e;

  typedef struct packed {
    logic     pwm_lo;
    logic     pwm_en;
    cmp_act_e act;
  } chan_ctrl_t;

  localparam logic [1:0] ADDR_MOD  = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_CMP  = 0;
  localparam int FLAG_OVF  = 1;

endpackage

// File: rtl/oc_timer_rst_sync.sv
module oc_timer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/oc_timer_regs.sv
module oc_timer_regs
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  output logic [CNT_W-1:0]     modulo,
  output logic [CNT_W-1:0]     cmp_val,
  output chan_ctrl_t           ctrl,
  output logic [NUM_FLAGS-1:0] clr_mask
);
  localparam int CTRL_W = $bits(chan_ctrl_t);

  logic [CNT_W-1:0] mod_q, mod_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  chan_ctrl_t       ctrl_q, ctrl_d;

  always_comb begin
    mod_d    = mod_q;
    cmp_d    = cmp_q;
    ctrl_d   = ctrl_q;
    clr_mask = '0;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_MOD:  mod_d    = wr_data;
        ADDR_CMP:  cmp_d    = wr_data;
        ADDR_CTRL: ctrl_d   = chan_ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_CLR:  clr_mask = wr_data[NUM_FLAGS-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '1;
      cmp_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      mod_q  <= mod_d;
      cmp_q  <= cmp_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign modulo  = mod_q;
  assign cmp_val = cmp_q;
  assign ctrl    = ctrl_q;

  // R7: a compare write is visible on the very next clock
  a_r7_cmp_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == ADDR_CMP |=> cmp_q == $past(wr_data));
endmodule

// File: rtl/oc_timer_counter.sv
module oc_timer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  always_comb begin
    at_top  = (cnt_q >= modulo);
    ovf_evt = tick && at_top;
    cnt_d   = cnt_q;
    if (tick) cnt_d = at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: wrap to zero at the top of the period
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt_q >= modulo |=> cnt_q == '0);
  // R2: single step below the top
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt_q < modulo |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3: frozen without a tick
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/oc_timer_compare.sv
module oc_timer_compare
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] modulo,
  input  chan_ctrl_t       ctrl,
  input  logic             ovf_evt,
  output logic             cmp_evt,
  output logic             pin
);
  logic     pin_q, pin_d;
  cmp_act_e act_sel;

  always_comb begin
    cmp_evt = tick && (cnt == cmp_val) && (cmp_val <= modulo);
    if (ctrl.pwm_en) act_sel = ctrl.pwm_lo ? ACT_SET : ACT_CLEAR;
    else             act_sel = ctrl.act;
    pin_d = pin_q;
    if (cmp_evt) begin
      unique case (act_sel)
        ACT_TOGGLE: pin_d = ~pin_q;
        ACT_CLEAR:  pin_d = 1'b0;
        ACT_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
    if (ctrl.pwm_en && ovf_evt) pin_d = ~ctrl.pwm_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin_q <= 1'b0;
    else if (tick) pin_q <= pin_d;
  end

  assign pin = pin_q;

  // R8 / R9 / R10: overflow drives the active level and wins ties
  a_r10_ovf_level: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.pwm_en && ovf_evt |=> pin_q == ~$past(ctrl.pwm_lo));
  // R3: pin frozen without a tick
  a_r3_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pin_q));
  // R4: no compare action leaves the pin alone in normal mode
  a_r4_none: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.pwm_en && ctrl.act == ACT_NONE |=> $stable(pin_q));
endmodule

// File: rtl/oc_timer_flags.sv
module oc_timer_flags
  import oc_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt,
  input  logic [NUM_FLAGS-1:0] clr_mask,
  output logic [NUM_FLAGS-1:0] flags
);
  logic [NUM_FLAGS-1:0] flg_q, flg_d;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_comb flg_d[i] = evt[i] | (flg_q[i] & ~clr_mask[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q[i] <= 1'b0;
      else        flg_q[i] <= flg_d[i];
    end

    // R5 / R2: an event always leaves its flag set
    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flg_q[i]);
    // R6: a flag only drops on a write-one clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flg_q[i] && !clr_mask[i] |=> flg_q[i]);
  end

  assign flags = flg_q;
endmodule

// File: rtl/oc_timer_chan.sv
module oc_timer_chan
  import oc_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pin_o,
  output logic             cmp_flag_o,
  output logic             ovf_flag_o
);
  logic                 rst_n_s;
  logic [CNT_W-1:0]     modulo, cmp_val, cnt;
  chan_ctrl_t           ctrl;
  logic [NUM_FLAGS-1:0] clr_mask, evt, flags;
  logic                 ovf_evt, cmp_evt;

  oc_timer_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  oc_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .modulo(modulo), .cmp_val(cmp_val),
    .ctrl(ctrl), .clr_mask(clr_mask));

  oc_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .tick(tick_en), .modulo(modulo),
    .cnt(cnt), .ovf_evt(ovf_evt));

  oc_timer_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n_s), .tick(tick_en), .cnt(cnt),
    .cmp_val(cmp_val), .modulo(modulo), .ctrl(ctrl),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .pin(pin_o));

  always_comb begin
    evt           = '0;
    evt[FLAG_CMP] = cmp_evt;
    evt[FLAG_OVF] = ovf_evt;
  end

  oc_timer_flags u_flags (
    .clk(clk), .rst_n(rst_n_s), .evt(evt), .clr_mask(clr_mask),
    .flags(flags));

  assign cnt_o      = cnt;
  assign cmp_flag_o = flags[FLAG_CMP];
  assign ovf_flag_o = flags[FLAG_OVF];

  // R1: everything idle straight out of reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n_s |=> cnt_o == '0 && !pin_o && !cmp_flag_o && !ovf_flag_o);
endmodule

// File: tb/tb_oc_timer_chan.sv
`timescale 1ns/1ps
module tb_oc_timer_chan;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n, tick_en, wr_en;
  logic [1:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic [W-1:0] cnt_o;
  logic         pin_o, cmp_flag_o, ovf_flag_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  oc_timer_chan #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cnt_o(cnt_o), .pin_o(pin_o),
    .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 count", int'(cnt_o), 0);
    check("R1 pin", int'(pin_o), 0);
    check("R1 cmp flag", int'(cmp_flag_o), 0);
    check("R1 ovf flag", int'(ovf_flag_o), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    wr(2'd0, 5);
    tick_en = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      check("R2 count", int'(cnt_o), i % 6);
      check("R2 ovf flag", int'(ovf_flag_o), (i >= 6) ? 1 : 0);
    end
    tick_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R3 hold count", int'(cnt_o), 0);
    end
  endtask

  task automatic t_toggle();
    int tog;
    do_reset();
    wr(2'd0, 5); wr(2'd1, 2); wr(2'd2, 1);
    tick_en = 1'b1;
    tog = 0;
    for (int i = 1; i <= 14; i++) begin
      if (((i - 1) % 6) == 2) tog++;
      @(negedge clk);
      check("R4 toggle pin", int'(pin_o), tog % 2);
      check("R5 cmp flag", int'(cmp_flag_o), (i >= 3) ? 1 : 0);
    end
    tick_en = 1'b0;
    wr(2'd3, 1);
    check("R6 cmp cleared", int'(cmp_flag_o), 0);
    check("R6 ovf kept", int'(ovf_flag_o), 1);
    wr(2'd3, 2);
    check("R6 ovf cleared", int'(ovf_flag_o), 0);
    check("R3 pin held", int'(pin_o), tog % 2);
  endtask

  task automatic t_set_clear();
    do_reset();
    wr(2'd0, 5); wr(2'd1, 1); wr(2'd2, 3);
    tick_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 set action", int'(pin_o), 1);
    tick_en = 1'b0;
    wr(2'd2, 2);
    tick_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 clear action", int'(pin_o), 0);
    tick_en = 1'b0;
    wr(2'd2, 0);
    wr(2'd3, 3);
    tick_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 none keeps pin", int'(pin_o), 0);
    tick_en = 1'b0;
  endtask

  task automatic t_missed();
    do_reset();
    wr(2'd0, 9); wr(2'd1, 6); wr(2'd2, 1);
    tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    check("R7 count before write", int'(cnt_o), 5);
    wr(2'd1, 3);
    tick_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R7 no compare this period", int'(cmp_flag_o), 0);
      check("R7 pin unchanged", int'(pin_o), 0);
    end
    check("R7 wrapped", int'(cnt_o), 0);
    repeat (4) @(negedge clk);
    check("R7 compare next period", int'(cmp_flag_o), 1);
    check("R7 pin toggled", int'(pin_o), 1);
    tick_en = 1'b0;
  endtask

  task automatic t_pwm(int m, int c, int lo, int cycles, string req);
    int exp;
    do_reset();
    wr(2'd0, m); wr(2'd1, c); wr(2'd2, 4 + 8 * lo);
    tick_en = 1'b1;
    do @(negedge clk); while (cnt_o != 0);
    for (int i = 0; i < cycles; i++) begin
      exp = (int'(cnt_o) <= c) ? 1 : 0;
      if (lo != 0) exp = 1 - exp;
      check(req, int'(pin_o), exp);
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_toggle();
    t_set_clear();
    t_missed();
    t_pwm(9, 3, 0, 30, "R8 active-high pwm");
    t_pwm(9, 0, 0, 20, "R8 minimum width");
    t_pwm(9, 3, 1, 30, "R9 active-low pwm");
    t_pwm(9, 9, 0, 20, "R10 cmp equals modulo");
    t_pwm(9, 12, 0, 20, "R10 cmp above modulo");
    t_pwm(9, 12, 1, 20, "R10 cmp above modulo low");
    t_pwm(255, 127, 0, 520, "R11 full 8-bit period");
    t_pwm(0, 0, 0, 5, "R11 one-tick period");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule